// File: doc/BRIEF.md
# Five-Channel Compare/Capture Timer Array

This block has one 16-bit time base and a set of channels that share it. Each channel has its own mode byte and its own 16-bit value register. A channel can latch the time base when an edge arrives on its input pin. It can raise a flag when the time base reaches a programmed value. It can toggle its output pin on that event, or it can drive an 8-bit pulse-width output from the low byte of the time base. The last channel can also issue a one-cycle reset request when it matches. This gives a watchdog: software keeps moving the value ahead of the counter so that the match never happens.

The time base can advance on every clock, on every PRESC_DIV-th clock, or on each synchronized rising edge of an external input. A control bit can freeze it while the idle input is high. A wrap flag is set when the counter passes from FFFFh to 0000h. The channel flags and the wrap flag are merged into one registered interrupt output, and each source has its own enable. A simple byte-wide write bus sets every register. The counter, the value registers and the flags are visible on output ports.

Top module: `pca_top`

## Requirements
- R1: With control bit 0 (run) set, the counter adds one for each tick. Control bits 3:2 pick the tick source: 0 is every clock, 1 is one clock in PRESC_DIV, 2 is each rising edge of `ext_clk_i` after a two-flop synchronizer, and 3 gives no ticks. The control register is at address 0. Writes to address 2 load the low count byte and writes to address 3 load the high byte.
- R2: While control bit 1 is set and `idle_i` is high, the counter holds its value. When control bit 1 is clear, `idle_i` has no effect.
- R3: A tick at count FFFFh wraps the count to 0000h and sets the wrap flag (`ovf_flag_o`, bit 7 of the flag register).
- R4: Mode byte bit 0 captures the count into a channel's value on a rising input edge, and bit 1 captures it on a falling edge. Setting both captures on either edge. A capture sets the channel flag. An edge whose bit is clear is ignored. Mode bytes are at address 8+n. Value low and high bytes are at addresses 16+n and 24+n.
- R5: With mode bits 2 (compare) and 3 (match) set, the channel flag is set once when the counter steps onto the channel value.
- R6: `irq_o` is high one cycle after any channel flag whose mode bit 6 is set, or after the wrap flag while control bit 4 is set.
- R7: With mode bits 2, 3 and 4 set, the channel output toggles on each match.
- R8: With mode bits 2 and 5 set, the channel output is registered high when the counter low byte is at or above the value low byte, and low otherwise. Over 256 ticks it is high for 256 minus that byte.
- R9: In that pulse-width mode, the value high byte is copied into the low byte on the tick at which the counter low byte wraps from FFh. A write to the high byte therefore takes effect only at the next period.
- R10: While control bit 5 is set, a match on the last channel gives a one-cycle pulse on `wdog_rst_o`. Moving the value ahead of the counter before it gets there prevents the pulse. With bit 5 clear, no pulse is produced.
- R11: A write to address 1 loads the channel flags from data bits [NMOD-1:0] and the wrap flag from bit 7. Writing zeros clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Write data byte |
| idle_i | input | 1 | System idle indication |
| ext_clk_i | input | 1 | External count input |
| cex_i | input | NMOD | Channel capture inputs |
| count_o | output | 16 | Time base value |
| val_o | output | NMOD*16 | Channel value registers, channel n at bits [16n+15:16n] |
| flags_o | output | NMOD | Channel event flags |
| ovf_flag_o | output | 1 | Counter wrap flag |
| irq_o | output | 1 | Combined interrupt |
| cex_o | output | NMOD | Channel outputs |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The bench checks edge selectivity. A capture channel set for rising edges must leave its value untouched on a falling edge; a design that reacts to both edges would overwrite the value. It also checks the pulse-width reload timing: a new high byte has to stay out of the low byte until the period wraps, and a design that copies it early would show the new byte mid-period. Duty cycles are measured over a whole period at two settings, so an off-by-one comparison would come out one count too high or too low. For the watchdog, the bench counts pulses for a plain match, for a match with the enable clear, and for a value rewritten ahead of the counter. A level output instead of a pulse, or a missed rewrite, would give a count other than the expected one.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int ADDR_W      = 5;
  localparam int ADDR_CTL    = 0;
  localparam int ADDR_FLAGS  = 1;
  localparam int ADDR_CNT_LO = 2;
  localparam int ADDR_CNT_HI = 3;
  localparam int BASE_MODE   = 8;
  localparam int BASE_VAL_LO = 16;
  localparam int BASE_VAL_HI = 24;

  typedef struct packed {
    logic irq_en;
    logic pwm;
    logic toggle;
    logic match;
    logic cmp;
    logic cap_fall;
    logic cap_rise;
  } mode_t;

  typedef struct packed {
    logic       wdog_en;
    logic       ovf_irq_en;
    logic [1:0] src;
    logic       idle_stop;
    logic       run;
  } ctl_t;
endpackage

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int PRESC_DIV   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pca_pkg::ctl_t    ctl,
  input  logic             idle_i,
  input  logic             ext_i,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             flag_wr,
  input  logic             flag_wbit,
  output logic [CNT_W-1:0] count,
  output logic             stepped,
  output logic             cl_wrap,
  output logic             ovf_flag
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0]          pre_q;
  logic [SYNC_STAGES-1:0] ext_sync;
  logic                   ext_prev;
  logic                   src_tick, tick, any_wr;

  assign any_wr = wr_lo | wr_hi;

  always_comb begin
    case (ctl.src)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = (pre_q == PW'(PRESC_DIV - 1));
      2'd2:    src_tick = ext_sync[SYNC_STAGES-1] & ~ext_prev;
      default: src_tick = 1'b0;
    endcase
  end

  assign tick    = ctl.run & ~(ctl.idle_stop & idle_i) & src_tick;
  assign cl_wrap = tick & ~any_wr & (count[7:0] == 8'hFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      ext_sync <= '0;
      ext_prev <= 1'b0;
      count    <= '0;
      stepped  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      pre_q    <= (pre_q == PW'(PRESC_DIV - 1)) ? '0 : pre_q + 1'b1;
      ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_i};
      ext_prev <= ext_sync[SYNC_STAGES-1];
      stepped  <= tick & ~any_wr;
      if (wr_lo) count[7:0]        <= wr_data;
      if (wr_hi) count[CNT_W-1:8]  <= wr_data[CNT_W-9:0];
      if (tick && !any_wr) count   <= count + 1'b1;
      if (flag_wr) ovf_flag <= flag_wbit;
      if (tick && !any_wr && (count == {CNT_W{1'b1}})) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pca_channel.sv
module pca_channel #(
  parameter int  SYNC_STAGES = 2,
  parameter int  CNT_W       = 16,
  parameter bit  IS_WDOG     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  pca_pkg::mode_t   mode,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             flag_wr,
  input  logic             flag_wbit,
  input  logic [CNT_W-1:0] count,
  input  logic             stepped,
  input  logic             cl_wrap,
  input  logic             wdog_en,
  input  logic             cex_i,
  output logic [CNT_W-1:0] val,
  output logic             flag,
  output logic             cex_o,
  output logic             wdog_req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise, fall, cap_hit, hit, pwm_on;

  assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall    = ~sync_q[SYNC_STAGES-1] & prev_q;
  assign cap_hit = (mode.cap_rise & rise) | (mode.cap_fall & fall);
  assign hit     = mode.cmp & mode.match & stepped & (count == val);
  assign pwm_on  = mode.cmp & mode.pwm;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      val    <= '0;
      flag   <= 1'b0;
      cex_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cex_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (pwm_on && cl_wrap) val[7:0] <= val[15:8];
      if (cap_hit) val <= count;
      if (wr_lo) val[7:0]        <= wr_data;
      if (wr_hi) val[CNT_W-1:8]  <= wr_data[CNT_W-9:0];
      if (flag_wr) flag <= flag_wbit;
      if (cap_hit || hit) flag <= 1'b1;
      if (pwm_on) cex_o <= (count[7:0] >= val[7:0]);
      else if (mode.toggle && hit) cex_o <= ~cex_o;
    end
  end

  generate
    if (IS_WDOG) begin : g_wdog
      always_ff @(posedge clk) begin
        if (rst) wdog_req <= 1'b0;
        else     wdog_req <= wdog_en & hit;
      end
    end else begin : g_plain
      assign wdog_req = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pca_top.sv
module pca_top #(
  parameter int NMOD        = 5,
  parameter int PRESC_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [4:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 idle_i,
  input  logic                 ext_clk_i,
  input  logic [NMOD-1:0]      cex_i,
  output logic [15:0]          count_o,
  output logic [NMOD*16-1:0]   val_o,
  output logic [NMOD-1:0]      flags_o,
  output logic                 ovf_flag_o,
  output logic                 irq_o,
  output logic [NMOD-1:0]      cex_o,
  output logic                 wdog_rst_o
);
  import pca_pkg::*;
  localparam int CNT_W = 16;

  ctl_t            ctl_q;
  mode_t           mode_q [NMOD];
  logic [NMOD-1:0] wdog_vec, irq_en_vec;
  logic            stepped, cl_wrap, flag_wr;
  logic            idle_stop_q;

  assign flag_wr     = wr_en && (wr_addr == ADDR_W'(ADDR_FLAGS));
  assign idle_stop_q = ctl_q.idle_stop;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(ADDR_CTL)) ctl_q <= ctl_t'(wr_data[5:0]);
  end

  pca_timebase #(.PRESC_DIV(PRESC_DIV), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .ctl(ctl_q), .idle_i(idle_i), .ext_i(ext_clk_i),
    .wr_lo(wr_en && wr_addr == ADDR_W'(ADDR_CNT_LO)),
    .wr_hi(wr_en && wr_addr == ADDR_W'(ADDR_CNT_HI)),
    .wr_data(wr_data), .flag_wr(flag_wr), .flag_wbit(wr_data[7]),
    .count(count_o), .stepped(stepped), .cl_wrap(cl_wrap), .ovf_flag(ovf_flag_o)
  );

  generate
    for (genvar g = 0; g < NMOD; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) mode_q[g] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(BASE_MODE + g)) mode_q[g] <= mode_t'(wr_data[6:0]);
      end
      assign irq_en_vec[g] = mode_q[g].irq_en;

      pca_channel #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .IS_WDOG(g == NMOD - 1)) u_ch (
        .clk(clk), .rst(rst), .mode(mode_q[g]),
        .wr_lo(wr_en && wr_addr == ADDR_W'(BASE_VAL_LO + g)),
        .wr_hi(wr_en && wr_addr == ADDR_W'(BASE_VAL_HI + g)),
        .wr_data(wr_data), .flag_wr(flag_wr), .flag_wbit(wr_data[g]),
        .count(count_o), .stepped(stepped), .cl_wrap(cl_wrap), .wdog_en(ctl_q.wdog_en),
        .cex_i(cex_i[g]), .val(val_o[g*16 +: 16]), .flag(flags_o[g]),
        .cex_o(cex_o[g]), .wdog_req(wdog_vec[g])
      );
    end
  endgenerate

  assign wdog_rst_o = |wdog_vec;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flags_o & irq_en_vec) | (ovf_flag_o & ctl_q.ovf_irq_en);
  end
endmodule

// File: rtl/pca_top_chk.sv
module pca_top_chk #(
  parameter int NMOD = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            idle_i,
  input logic            idle_stop,
  input logic [15:0]     count_o,
  input logic [NMOD-1:0] flags_o,
  input logic            ovf_flag_o,
  input logic            irq_o,
  input logic            wdog_rst_o
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && count_o != $past(count_o)) |-> count_o == 16'($past(count_o) + 16'd1)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(idle_i && idle_stop) && !$past(wr_en)) |-> $stable(count_o)); // R2
  AST_OVF_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag_o) && !$past(wr_en)) |-> ($past(count_o) == 16'hFFFF && count_o == 16'h0000)); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flags_o != '0 || ovf_flag_o)); // R6
  AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> !wdog_rst_o); // R10
endmodule

bind pca_top pca_top_chk #(.NMOD(NMOD)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .idle_i(idle_i), .idle_stop(idle_stop_q),
  .count_o(count_o), .flags_o(flags_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
  .wdog_rst_o(wdog_rst_o)
);

// File: tb/pca_top_tb_top.sv
`timescale 1ns/1ps
module pca_top_tb_top;
  localparam int NMOD = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [4:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic            idle_i = 1'b0;
  logic            ext_clk_i = 1'b0;
  logic [NMOD-1:0] cex_i = '0;
  logic [15:0]     count_o;
  logic [NMOD*16-1:0] val_o;
  logic [NMOD-1:0] flags_o, cex_o;
  logic            ovf_flag_o, irq_o, wdog_rst_o;

  always #2 clk = ~clk;

  pca_top #(.NMOD(NMOD), .PRESC_DIV(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle_i(idle_i), .ext_clk_i(ext_clk_i), .cex_i(cex_i), .count_o(count_o),
    .val_o(val_o), .flags_o(flags_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
    .cex_o(cex_o), .wdog_rst_o(wdog_rst_o)
  );

  typedef struct {
    string       req;
    logic [31:0] got;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    item_t it;
    it.req = req; it.got = got; it.exp = exp;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (it.got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %0h expected %0h", it.req, it.got, it.exp);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] valn(input int n);
    return val_o[n*16 +: 16];
  endfunction

  task automatic set_count(input int v);
    wr(2, v & 8'hFF);
    wr(3, (v >> 8) & 8'hFF);
  endtask

  task automatic set_val(input int n, input int v);
    wr(16 + n, v & 8'hFF);
    wr(24 + n, (v >> 8) & 8'hFF);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    int ones, pulses;
    idle_n(3);
    rst = 1'b0;
    idle_n(1);
    chk("R1 reset count", count_o, 0);
    chk("R11 reset flags", {ovf_flag_o, flags_o}, 0);
    chk("R6 reset irq", irq_o, 0);
    chk("R10 reset wdog", wdog_rst_o, 0);

    // R1 every-clock source
    wr(0, 8'h01);
    a = count_o; idle_n(10);
    chk("R1 clock source step", 16'(count_o - a), 10);
    // R1 prescaled source
    wr(0, 8'h05);
    a = count_o; idle_n(20);
    chk("R1 prescaled step", 16'(count_o - a), 5);
    // R1 external source
    wr(0, 8'h09);
    a = count_o;
    for (int i = 0; i < 3; i++) begin
      ext_clk_i = 1'b1; idle_n(3); ext_clk_i = 1'b0; idle_n(3);
    end
    idle_n(4);
    chk("R1 external edges", 16'(count_o - a), 3);
    // R2 idle gating
    wr(0, 8'h03); idle_i = 1'b1;
    a = count_o; idle_n(10);
    chk("R2 frozen in idle", 16'(count_o - a), 0);
    wr(0, 8'h01);
    a = count_o; idle_n(10);
    chk("R2 idle ignored when disabled", 16'(count_o - a), 10);
    idle_i = 1'b0;

    // R3 wrap flag and R6 wrap interrupt
    wr(0, 8'h00); set_count(16'hFFFE);
    chk("R3 no flag before wrap", ovf_flag_o, 0);
    wr(0, 8'h11); idle_n(5);
    wr(0, 8'h00);
    chk("R3 wrap flag", ovf_flag_o, 1);
    chk("R3 count wrapped", count_o < 16'h0010, 1);
    chk("R6 irq from wrap", irq_o, 1);
    wr(1, 8'h00); idle_n(2);
    chk("R11 wrap flag cleared", ovf_flag_o, 0);
    chk("R6 irq drops", irq_o, 0);

    // R4 capture
    set_count(16'h1234);
    wr(8 + 1, 8'h01);
    cex_i[1] = 1'b1; idle_n(5);
    chk("R4 rising capture", valn(1), 16'h1234);
    chk("R4 capture flag", flags_o[1], 1);
    set_count(16'h2222);
    cex_i[1] = 1'b0; idle_n(5);
    chk("R4 falling ignored", valn(1), 16'h1234);
    wr(8 + 1, 8'h03);
    cex_i[1] = 1'b1; idle_n(5);
    chk("R4 both edges rising", valn(1), 16'h2222);
    set_count(16'h3333);
    cex_i[1] = 1'b0; idle_n(5);
    chk("R4 both edges falling", valn(1), 16'h3333);
    wr(8 + 1, 8'h00);
    wr(1, 8'h00); idle_n(1);
    chk("R11 flags cleared", flags_o, 0);

    // R5 software timer with R6 interrupt
    wr(8 + 2, 8'h4C); set_val(2, 16'h0010); set_count(0);
    wr(0, 8'h01); idle_n(5);
    chk("R5 no flag before match", flags_o[2], 0);
    idle_n(30);
    wr(0, 8'h00);
    chk("R5 flag on match", flags_o[2], 1);
    chk("R6 irq from channel", irq_o, 1);
    wr(8 + 2, 8'h00); wr(1, 8'h00); idle_n(2);
    chk("R6 irq clears", irq_o, 0);

    // R7 toggle
    wr(8 + 3, 8'h1C); set_val(3, 16'h0008); set_count(0);
    chk("R7 output before match", cex_o[3], 0);
    wr(0, 8'h01); idle_n(20); wr(0, 8'h00);
    chk("R7 toggled once", cex_o[3], 1);
    wr(8 + 3, 8'h00); wr(1, 8'h00);

    // R8 and R9 pulse width
    wr(8 + 0, 8'h24); set_val(0, 16'h4040); set_count(0);
    wr(0, 8'h01); idle_n(2);
    ones = 0;
    for (int i = 0; i < 256; i++) begin @(negedge clk); ones += cex_o[0]; end
    chk("R8 duty at 40h", ones, 192);
    wr(0, 8'h00); set_count(16'h0010);
    wr(24 + 0, 8'hC0);
    chk("R9 low byte held", valn(0) & 16'h00FF, 16'h0040);
    wr(0, 8'h01); idle_n(250); wr(0, 8'h00);
    chk("R9 reload at wrap", valn(0) & 16'h00FF, 16'h00C0);
    wr(0, 8'h01); idle_n(2);
    ones = 0;
    for (int i = 0; i < 256; i++) begin @(negedge clk); ones += cex_o[0]; end
    chk("R8 duty at C0h", ones, 64);
    wr(0, 8'h00); wr(8 + 0, 8'h00);

    // R10 watchdog
    wr(8 + 4, 8'h0C); set_val(4, 16'h0030); set_count(0);
    wr(0, 8'h21);
    pulses = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); pulses += wdog_rst_o; end
    chk("R10 one pulse on match", pulses, 1);
    wr(0, 8'h00); set_count(0);
    wr(0, 8'h21);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); pulses += wdog_rst_o; end
    wr(16 + 4, 8'hF0);
    for (int i = 0; i < 60; i++) begin @(negedge clk); pulses += wdog_rst_o; end
    chk("R10 rewrite avoids reset", pulses, 0);
    wr(0, 8'h00); set_val(4, 16'h0030); set_count(0); wr(1, 8'h00);
    wr(0, 8'h01);
    pulses = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); pulses += wdog_rst_o; end
    wr(0, 8'h00);
    chk("R10 disabled no pulse", pulses, 0);
    chk("R5 last channel still flags", flags_o[4], 1);

    idle_n(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule